// File: doc/BRIEF.md
# Stereo Source Router with Silence Mute

This block takes one stereo pair of signed parallel audio words per frame and routes them onto a left and a right output. A frame strobe marks each new pair. Each output has its own two-bit source select. The select can send silence, the left input, the right input, or a mono mix (the rounded-down mean of both inputs) to that output. A single 4-bit control word carries both selects, so one write can set any pairing: pass-through, swapped channels, mono on both sides, or a single side silenced.

A silence detector can also be switched on. While it is enabled, it counts consecutive frames in which both input words are zero. When the run reaches a set length (1024 frames by default), the block forces both outputs to the zero code and raises a mute flag for the pair. The first frame with any non-zero word releases the mute at once.

All outputs are registered. They change only on the clock edge that samples the frame strobe.

Top module: `stereo_route_mute`

## Requirements
- R1: Bits [1:0] of `route_cfg` choose the source for `out_left`, and bits [3:2] choose the source for `out_right`. The two selects work independently of each other.
- R2: Select code 2'b00 gives the zero code, 2'b01 gives `in_left`, 2'b10 gives `in_right` and 2'b11 gives the mono mix. The value 4'b1001 therefore passes each input straight to its own side.
- R3: The mono mix equals floor((in_left + in_right) / 2). It is formed at one extra bit of width, so full-scale inputs of the same sign never wrap. For example, two maximum-positive words give the maximum-positive word, and -1 mixed with 0 gives -1.
- R4: Outputs and the mute flag take their new values on the rising clock edge where `frame_stb` is high. They hold their values on every edge where it is low.
- R5: While `rst_n` is low, both outputs and `pair_muted` are zero, and the run of zero frames is forgotten. After reset, a mute needs a full new run.
- R6: With `zmute_en` low, `pair_muted` stays low and routing is never overridden, however long the run of zero frames.
- R7: A frame counts as zero only when both input words are zero. A frame where only one word is non-zero restarts the run.
- R8: With `zmute_en` high, the frame that completes RUN_LEN consecutive zero frames sets `pair_muted` and drives both outputs to zero on that same update. The frame before it (RUN_LEN-1) does not.
- R9: While muted, the first frame with a non-zero word clears `pair_muted` and restores normal routing on that same update.
- R10: Further zero frames after the mute keep the pair muted, because the run counter saturates. Lowering `zmute_en` clears the run, so after it is raised again a full RUN_LEN zero frames are needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | High for one cycle per stereo frame |
| route_cfg | input | 4 | Source selects: [1:0] left output, [3:2] right output |
| zmute_en | input | 1 | Enables automatic mute on long runs of zero frames |
| in_left | input | DATA_W | Signed left input word |
| in_right | input | DATA_W | Signed right input word |
| out_left | output | DATA_W | Routed signed left output |
| out_right | output | DATA_W | Routed signed right output |
| pair_muted | output | 1 | High while the pair is held silent by the zero detector |

## Verification
The bench targets the mix at full scale with equal signs, and odd negative sums. A mix that drops the extra bit wraps to the opposite sign. A mix that truncates toward zero returns 0 for -1 mixed with 0. The run boundary is checked on frames RUN_LEN-1 and RUN_LEN, and with one side non-zero. An off-by-one counter mutes one frame early or late. A detector that looks at only one channel mutes during single-sided signal. The release frame, reset in the middle of a run, and a brief disable are also exercised. A design that delays the release, or keeps the old count across the disable or reset, leaves the pair muted or mutes it too soon.

// File: rtl/stereo_route_pkg.sv
package stereo_route_pkg;

  typedef enum logic [1:0] {
    SRC_MUTE  = 2'b00,
    SRC_LEFT  = 2'b01,
    SRC_RIGHT = 2'b10,
    SRC_MIX   = 2'b11
  } src_sel_e;

  localparam int SEL_W = 2;
  localparam int N_OUT = 2;

endpackage

// File: rtl/chan_select.sv
module chan_select
  import stereo_route_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic [SEL_W-1:0]         sel_i,
  input  logic signed [DATA_W-1:0] left_i,
  input  logic signed [DATA_W-1:0] right_i,
  output logic signed [DATA_W-1:0] word_o
);

  // Mean of two words: widen by one bit, add, drop the LSB (floor).
  function automatic logic signed [DATA_W-1:0] half_sum(
    input logic signed [DATA_W-1:0] a,
    input logic signed [DATA_W-1:0] b
  );
    logic signed [DATA_W:0] s;
    s = {a[DATA_W-1], a} + {b[DATA_W-1], b};
    return s[DATA_W:1];
  endfunction

  src_sel_e                 src;
  logic signed [DATA_W-1:0] mix_w;
  logic signed [DATA_W-1:0] lo_w;
  logic signed [DATA_W-1:0] hi_w;

  assign src   = src_sel_e'(sel_i);
  assign mix_w = half_sum(left_i, right_i);
  assign lo_w  = (left_i < right_i) ? left_i : right_i;
  assign hi_w  = (left_i < right_i) ? right_i : left_i;

  always_comb begin
    case (src)
      SRC_MUTE:  word_o = '0;
      SRC_LEFT:  word_o = left_i;
      SRC_RIGHT: word_o = right_i;
      SRC_MIX:   word_o = mix_w;
      default:   word_o = '0;
    endcase
  end

  // R3
  always_comb begin
    if (src == SRC_MIX) begin
      mix_bounded_chk: assert (word_o >= lo_w && word_o <= hi_w);
    end
  end

endmodule

// File: rtl/zero_run_tracker.sv
module zero_run_tracker #(
  parameter int RUN_LEN = 1024,
  localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             stb_i,
  input  logic             zero_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] run_cnt_o
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  logic             run_break;
  logic             run_step;

  assign run_break = !en_i || (stb_i && !zero_i);
  assign run_step  = stb_i && zero_i && (cnt_q != LIMIT);

  always_comb begin
    if (run_break)     cnt_next = '0;
    else if (run_step) cnt_next = cnt_q + 1'b1;
    else               cnt_next = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next;
  end

  assign hit_o     = (cnt_next == LIMIT);
  assign run_cnt_o = cnt_q;

  // R10
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R10
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> cnt_q == '0);

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && stb_i && zero_i && cnt_q < LIMIT) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R7
  nonzero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && !zero_i) |=> cnt_q == '0);

endmodule

// File: rtl/stereo_route_mute.sv
module stereo_route_mute
  import stereo_route_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int RUN_LEN = 1024,
  localparam int CFG_W  = SEL_W * N_OUT,
  localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_stb,
  input  logic [CFG_W-1:0]         route_cfg,
  input  logic                     zmute_en,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right,
  output logic                     pair_muted
);

  logic signed [DATA_W-1:0] routed [N_OUT];
  logic                     frame_zero;
  logic                     run_hit;
  logic [CNT_W-1:0]         run_cnt;

  // Index 0 feeds the left output, index 1 the right output.
  for (genvar g = 0; g < N_OUT; g++) begin : g_sel
    chan_select #(.DATA_W(DATA_W)) u_sel (
      .sel_i  (route_cfg[g*SEL_W +: SEL_W]),
      .left_i (in_left),
      .right_i(in_right),
      .word_o (routed[g])
    );
  end

  assign frame_zero = (in_left == '0) && (in_right == '0);

  zero_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (zmute_en),
    .stb_i    (frame_stb),
    .zero_i   (frame_zero),
    .hit_o    (run_hit),
    .run_cnt_o(run_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_left   <= '0;
      out_right  <= '0;
      pair_muted <= 1'b0;
    end else if (frame_stb) begin
      pair_muted <= run_hit;
      out_left   <= run_hit ? '0 : routed[0];
      out_right  <= run_hit ? '0 : routed[1];
    end
  end

  // R8
  muted_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_muted |-> (out_left == '0 && out_right == '0));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !frame_zero) |=> !pair_muted);

  // R6
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !zmute_en) |=> !pair_muted);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(out_left) && $stable(out_right) && $stable(pair_muted)));

  // R10
  mute_needs_full_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && run_hit) |-> (run_cnt >= CNT_W'(RUN_LEN - 1)));

endmodule

// File: tb/stereo_route_mute_tb.sv
module stereo_route_mute_tb;

  localparam int W   = 24;
  localparam int RUN = 1024;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                frame_stb = 1'b0;
  logic [3:0]          route_cfg = 4'b1001;
  logic                zmute_en = 1'b0;
  logic signed [W-1:0] in_left = '0;
  logic signed [W-1:0] in_right = '0;
  logic signed [W-1:0] out_left;
  logic signed [W-1:0] out_right;
  logic                pair_muted;

  int  n_checks = 0;
  int  n_err    = 0;
  int  run_m    = 0;
  bit  done     = 1'b0;
  longint exp_l = 0;
  longint exp_r = 0;
  bit  exp_m    = 1'b0;

  always #10 clk = ~clk;

  stereo_route_mute #(.DATA_W(W), .RUN_LEN(RUN)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .route_cfg(route_cfg),
    .zmute_en(zmute_en), .in_left(in_left), .in_right(in_right),
    .out_left(out_left), .out_right(out_right), .pair_muted(pair_muted)
  );

  // Source picked by one 2-bit code; mix uses wide arithmetic and floor.
  function automatic longint pick(input int code, input longint l, input longint r);
    longint s;
    s = l + r;
    case (code)
      1: return l;
      2: return r;
      3: return (s - ((s % 2 + 2) % 2)) / 2;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    n_checks++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic check_outs(input string req);
    chk(req, "out_left", longint'(out_left), exp_l);
    chk(req, "out_right", longint'(out_right), exp_r);
    chk(req, "pair_muted", longint'(pair_muted), longint'(exp_m));
  endtask

  task automatic frame(input logic signed [W-1:0] l, input logic signed [W-1:0] r,
                       input logic [3:0] cfg, input logic en, input string req, input bit do_chk);
    @(negedge clk);
    in_left = l; in_right = r; route_cfg = cfg; zmute_en = en; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    if (!en || l != 0 || r != 0) run_m = 0;
    else if (run_m < RUN) run_m++;
    exp_m = en && (run_m == RUN);
    exp_l = exp_m ? 0 : pick(int'(cfg[1:0]), longint'(l), longint'(r));
    exp_r = exp_m ? 0 : pick(int'(cfg[3:2]), longint'(l), longint'(r));
    if (do_chk) check_outs(req);
  endtask

  task automatic zeros(input int n, input logic en, input string req, input bit chk_each);
    for (int i = 0; i < n; i++) frame('0, '0, 4'b1001, en, req, chk_each);
  endtask

  function automatic logic signed [W-1:0] rnd_word();
    if (($urandom % 8) == 0) return '0;
    return W'($urandom);
  endfunction

  localparam logic signed [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MAXN = {1'b1, {(W-1){1'b0}}};

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd7331);
    repeat (3) @(negedge clk);
    // R5: reset state
    exp_l = 0; exp_r = 0; exp_m = 0;
    check_outs("R5");
    @(negedge clk); rst_n = 1'b1;

    // R1 R2: every select pairing with directed values
    for (int c = 0; c < 16; c++) frame(24'sd1000, -24'sd300, 4'(c), 1'b0, "R1", 1'b1);
    frame(24'sd5, 24'sd9, 4'b1001, 1'b0, "R2", 1'b1);
    frame(24'sd5, 24'sd9, 4'b0110, 1'b0, "R2", 1'b1);

    // R3: mix corners
    frame(MAXP, MAXP, 4'b1111, 1'b0, "R3", 1'b1);
    frame(MAXN, MAXN, 4'b1111, 1'b0, "R3", 1'b1);
    frame(-24'sd1, 24'sd0, 4'b1111, 1'b0, "R3", 1'b1);
    frame(24'sd1, 24'sd0, 4'b1111, 1'b0, "R3", 1'b1);
    frame(MAXP, MAXN, 4'b1111, 1'b0, "R3", 1'b1);

    // R1 R2 R3: constrained random
    for (int i = 0; i < 300; i++)
      frame(rnd_word(), rnd_word(), 4'($urandom), 1'($urandom), "R2", 1'b1);

    // R4: outputs hold while strobe is low
    frame(24'sd77, 24'sd88, 4'b1001, 1'b0, "R4", 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_left = W'($urandom); in_right = W'($urandom); route_cfg = 4'($urandom);
      check_outs("R4");
    end

    // R8: boundary of the run
    frame(24'sd1, 24'sd0, 4'b1001, 1'b1, "R8", 1'b1);
    zeros(RUN - 1, 1'b1, "R8", 1'b0);
    check_outs("R8");
    chk("R8", "muted before run end", longint'(pair_muted), 0);
    frame('0, '0, 4'b1111, 1'b1, "R8", 1'b1);
    chk("R8", "muted at run end", longint'(pair_muted), 1);
    // R10: saturation keeps mute
    zeros(5, 1'b1, "R10", 1'b1);
    // R9 R7: release on one-sided non-zero frame
    frame('0, 24'sd3, 4'b1001, 1'b1, "R9", 1'b1);
    chk("R9", "released", longint'(pair_muted), 0);
    // R7: one-sided non-zero restarts run
    zeros(RUN - 1, 1'b1, "R7", 1'b0);
    frame(-24'sd2, '0, 4'b1001, 1'b1, "R7", 1'b1);
    frame('0, '0, 4'b1001, 1'b1, "R7", 1'b1);
    chk("R7", "not muted after restart", longint'(pair_muted), 0);

    // R6: disabled detector never mutes
    zeros(RUN + 50, 1'b0, "R6", 1'b0);
    check_outs("R6");
    chk("R6", "muted while disabled", longint'(pair_muted), 0);

    // R10: brief disable clears the run
    zeros(600, 1'b1, "R10", 1'b0);
    frame('0, '0, 4'b1001, 1'b0, "R10", 1'b1);
    zeros(600, 1'b1, "R10", 1'b0);
    check_outs("R10");
    chk("R10", "muted after cleared run", longint'(pair_muted), 0);
    zeros(RUN - 600, 1'b1, "R10", 1'b0);
    check_outs("R10");

    // R5: reset mid-run forgets the count
    frame(24'sd4, 24'sd4, 4'b1001, 1'b1, "R5", 1'b1);
    zeros(600, 1'b1, "R5", 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    exp_l = 0; exp_r = 0; exp_m = 0; run_m = 0;
    check_outs("R5");
    rst_n = 1'b1;
    zeros(600, 1'b1, "R5", 1'b0);
    check_outs("R5");

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

endmodule